// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block produces the instruction fetch address of a small 4-bit microcontroller core. The fetch space is 8192 words, organised as 2 banks × 16 pages × 256 steps. The 13-bit address is `{bank, page, step}`, with bank in bit 12, page in bits 11:8 and step in bits 7:0. Each clock cycle the instruction decoder asserts at most one strobe. The sequencer then advances the step, branches, calls or returns. It also exposes the 12-bit `{page, step}` value that a call pushes to the stack.

Jumps and calls stay in the current page unless the instruction just before them was a page-set. A page-set loads a pending bank and a pending page. The pending values apply only to the next instruction. After any other instruction they fall back to the current bank and page. A zero-page call always lands in bank 0, page 0, and discards any pending value.

Top module: `banked_pc_seq`

## Requirements
- R1: A synchronous active-low reset sets the fetch address to 0x100 (bank 0, page 1, step 0) and discards any pending page-set data.
- R2: A step-advance strobe or a page-set strobe adds one to the step field, modulo 256, and leaves bank and page unchanged. A cycle with no strobe holds the address.
- R3: A jump with no page-set just before it loads the step from the 8-bit operand and keeps the current bank and page.
- R4: Page-set operand bit 4 becomes the pending bank and bits 3..0 become the pending page. A jump or call that immediately follows uses them as its bank and page.
- R5: Pending page-set data affects only the instruction right after the page-set. After any other instruction, the pending values equal the current bank and page.
- R6: A conditional jump is taken only when its condition holds; otherwise the step advances by one. Condition select 00 means carry=1, 01 means carry=0, 10 means zero=1, and 11 means zero=0.
- R7: A call goes to the same target as a jump would. `push_val_o` always equals `{page, step+1 mod 256}` of the current address.
- R8: A zero-page call goes to bank 0, page 0, step = operand. The pending data is cancelled, so the next jump stays in page 0.
- R9: A return sets page to `ret_val_i[11:8]` and step to `ret_val_i[7:0]`. The bank does not change.
- R10: A return-and-skip restores the address in the same way as a return, then adds one to the step modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_i | input | 1 | Advance step by one |
| pset_i | input | 1 | Page-set instruction (also advances the step) |
| jump_i | input | 1 | Unconditional jump |
| jcond_i | input | 1 | Conditional jump |
| call_i | input | 1 | Subroutine call |
| callz_i | input | 1 | Zero-page call |
| ret_i | input | 1 | Return |
| retskip_i | input | 1 | Return and skip one instruction |
| cond_sel_i | input | 2 | Condition select for a conditional jump |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| step_op_i | input | 8 | Step operand for jumps and calls |
| page_op_i | input | 5 | Page-set operand: {bank, page} |
| ret_val_i | input | 12 | {page, step} read back from the stack |
| fetch_addr_o | output | 13 | Current fetch address {bank, page, step} |
| push_val_o | output | 12 | Return value for a call to push |

## Verification
A corrupted pending register shows up at the port on the first jump or call after the page-set, as a wrong bank or page. A stale pending value that outlives its one instruction shows up on the following jump, as an unexpected bank or page change. Step, carry and condition errors appear in `fetch_addr_o` one cycle after the strobe. A wrong push value is visible in the same cycle, because it is computed from the current address.

// File: rtl/pcseq_pkg.sv
// Package: shared widths and the condition-select encoding for the
// banked program counter sequencer. Assumes one bank bit, four page
// bits and eight step bits unless a user overrides module parameters.
package pcseq_pkg;
    localparam int BANK_W = 1;
    localparam int PAGE_W = 4;
    localparam int STEP_W = 8;

    typedef enum logic [1:0] {
        CC_CARRY_SET = 2'b00,
        CC_CARRY_CLR = 2'b01,
        CC_ZERO_SET  = 2'b10,
        CC_ZERO_CLR  = 2'b11
    } cond_e;
endpackage

// File: rtl/pcseq_cond.sv
// Condition evaluator: decides whether a conditional jump is taken.
// Assumes the flags are stable for the cycle the strobe is asserted.
module pcseq_cond
    import pcseq_pkg::*;
(
    input  logic [1:0] cond_sel,
    input  logic       carry,
    input  logic       zero,
    output logic       met
);
    // Select the flag test named by the condition code.
    always_comb begin
        unique case (cond_e'(cond_sel))
            CC_CARRY_SET: met = carry;
            CC_CARRY_CLR: met = !carry;
            CC_ZERO_SET:  met = zero;
            CC_ZERO_CLR:  met = !zero;
            default:      met = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcseq_pending.sv
// Pending bank/page holder. A page-set loads it from the operand.
// Every other instruction reloads it with the bank and page the counter
// moves to, so it mirrors the current page whenever no page-set is live.
// Idle cycles leave it alone.
module pcseq_pending #(
    parameter int BANK_W     = pcseq_pkg::BANK_W,
    parameter int PAGE_W     = pcseq_pkg::PAGE_W,
    parameter int RESET_BANK = 0,
    parameter int RESET_PAGE = 1,
    localparam int OP_W      = BANK_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pset,
    input  logic              other_instr,
    input  logic [OP_W-1:0]   pset_op,
    input  logic [BANK_W-1:0] nxt_bank,
    input  logic [PAGE_W-1:0] nxt_page,
    output logic [BANK_W-1:0] pend_bank,
    output logic [PAGE_W-1:0] pend_page
);
    // Load from the operand on page-set, track the counter otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_bank <= BANK_W'(RESET_BANK);
            pend_page <= PAGE_W'(RESET_PAGE);
        end else if (pset) begin
            pend_bank <= pset_op[OP_W-1:PAGE_W];
            pend_page <= pset_op[PAGE_W-1:0];
        end else if (other_instr) begin
            pend_bank <= nxt_bank;
            pend_page <= nxt_page;
        end
    end
endmodule

// File: rtl/pcseq_next.sv
// Next-address selector. Picks the following bank/page/step from the
// strobes. Assumes at most one strobe per cycle; if several are high,
// the fixed order is: return-skip, return, zero-page call, call, jump,
// conditional jump, then advance.
module pcseq_next #(
    parameter int BANK_W = pcseq_pkg::BANK_W,
    parameter int PAGE_W = pcseq_pkg::PAGE_W,
    parameter int STEP_W = pcseq_pkg::STEP_W,
    localparam int RET_W = PAGE_W + STEP_W
) (
    input  logic [BANK_W-1:0] cur_bank,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [STEP_W-1:0] cur_step,
    input  logic [BANK_W-1:0] pend_bank,
    input  logic [PAGE_W-1:0] pend_page,
    input  logic              inc,
    input  logic              pset,
    input  logic              jump,
    input  logic              jcond,
    input  logic              cond_met,
    input  logic              call,
    input  logic              callz,
    input  logic              ret,
    input  logic              retskip,
    input  logic [STEP_W-1:0] step_op,
    input  logic [RET_W-1:0]  ret_val,
    output logic [BANK_W-1:0] nxt_bank,
    output logic [PAGE_W-1:0] nxt_page,
    output logic [STEP_W-1:0] nxt_step
);
    logic [STEP_W-1:0] step_plus;
    logic [STEP_W-1:0] ret_step;

    // Step successor, wrapping inside the page.
    assign step_plus = STEP_W'(cur_step + 1'b1);
    assign ret_step  = ret_val[STEP_W-1:0];

    // Choose the next counter value by strobe priority.
    always_comb begin
        nxt_bank = cur_bank;
        nxt_page = cur_page;
        nxt_step = cur_step;
        if (retskip) begin
            nxt_page = ret_val[RET_W-1:STEP_W];
            nxt_step = STEP_W'(ret_step + 1'b1);
        end else if (ret) begin
            nxt_page = ret_val[RET_W-1:STEP_W];
            nxt_step = ret_step;
        end else if (callz) begin
            nxt_bank = '0;
            nxt_page = '0;
            nxt_step = step_op;
        end else if (call || jump || (jcond && cond_met)) begin
            nxt_bank = pend_bank;
            nxt_page = pend_page;
            nxt_step = step_op;
        end else if (inc || pset || jcond) begin
            nxt_step = step_plus;
        end
    end
endmodule

// File: rtl/banked_pc_seq.sv
// Top: banked program counter sequencer. Holds the bank/page/step
// counter, instantiates the condition test, pending holder and
// next-address selector. Assumes the decoder gives at most one strobe
// per cycle and that the stack side writes push_val_o on a call.
module banked_pc_seq #(
    parameter int BANK_W     = pcseq_pkg::BANK_W,
    parameter int PAGE_W     = pcseq_pkg::PAGE_W,
    parameter int STEP_W     = pcseq_pkg::STEP_W,
    parameter int RESET_BANK = 0,
    parameter int RESET_PAGE = 1,
    localparam int OP_W      = BANK_W + PAGE_W,
    localparam int RET_W     = PAGE_W + STEP_W,
    localparam int ADDR_W    = BANK_W + RET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              pset_i,
    input  logic              jump_i,
    input  logic              jcond_i,
    input  logic              call_i,
    input  logic              callz_i,
    input  logic              ret_i,
    input  logic              retskip_i,
    input  logic [1:0]        cond_sel_i,
    input  logic              carry_i,
    input  logic              zero_i,
    input  logic [STEP_W-1:0] step_op_i,
    input  logic [OP_W-1:0]   page_op_i,
    input  logic [RET_W-1:0]  ret_val_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [RET_W-1:0]  push_val_o
);
    logic [BANK_W-1:0] bank_q, nxt_bank, pend_bank;
    logic [PAGE_W-1:0] page_q, nxt_page, pend_page;
    logic [STEP_W-1:0] step_q, nxt_step;
    logic              cond_met;
    logic              other_instr;

    // Any executed instruction that is not a page-set.
    assign other_instr = inc_i | jump_i | jcond_i | call_i | callz_i
                       | ret_i | retskip_i;

    pcseq_cond u_cond (
        .cond_sel (cond_sel_i),
        .carry    (carry_i),
        .zero     (zero_i),
        .met      (cond_met)
    );

    pcseq_pending #(
        .BANK_W     (BANK_W),
        .PAGE_W     (PAGE_W),
        .RESET_BANK (RESET_BANK),
        .RESET_PAGE (RESET_PAGE)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .pset        (pset_i),
        .other_instr (other_instr),
        .pset_op     (page_op_i),
        .nxt_bank    (nxt_bank),
        .nxt_page    (nxt_page),
        .pend_bank   (pend_bank),
        .pend_page   (pend_page)
    );

    pcseq_next #(
        .BANK_W (BANK_W),
        .PAGE_W (PAGE_W),
        .STEP_W (STEP_W)
    ) u_next (
        .cur_bank  (bank_q),
        .cur_page  (page_q),
        .cur_step  (step_q),
        .pend_bank (pend_bank),
        .pend_page (pend_page),
        .inc       (inc_i),
        .pset      (pset_i),
        .jump      (jump_i),
        .jcond     (jcond_i),
        .cond_met  (cond_met),
        .call      (call_i),
        .callz     (callz_i),
        .ret       (ret_i),
        .retskip   (retskip_i),
        .step_op   (step_op_i),
        .ret_val   (ret_val_i),
        .nxt_bank  (nxt_bank),
        .nxt_page  (nxt_page),
        .nxt_step  (nxt_step)
    );

    // Counter register: reset vector, then the selected next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= BANK_W'(RESET_BANK);
            page_q <= PAGE_W'(RESET_PAGE);
            step_q <= '0;
        end else begin
            bank_q <= nxt_bank;
            page_q <= nxt_page;
            step_q <= nxt_step;
        end
    end

    // Outputs: fetch address and the return value a call pushes.
    assign fetch_addr_o = {bank_q, page_q, step_q};
    assign push_val_o   = {page_q, STEP_W'(step_q + 1'b1)};
endmodule

// File: rtl/pcseq_chk.sv
// Checker for banked_pc_seq: temporal properties on its ports,
// attached with bind. Assumes default field widths.
module pcseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        inc_i,
    input logic        pset_i,
    input logic        jump_i,
    input logic        jcond_i,
    input logic        call_i,
    input logic        callz_i,
    input logic        ret_i,
    input logic        retskip_i,
    input logic [1:0]  cond_sel_i,
    input logic        carry_i,
    input logic [7:0]  step_op_i,
    input logic [11:0] ret_val_i,
    input logic [12:0] fetch_addr_o,
    input logic [11:0] push_val_o
);
    logic [7:0] strobes;
    logic       prev_other;

    assign strobes = {inc_i, pset_i, jump_i, jcond_i, call_i, callz_i, ret_i, retskip_i};

    // Remember whether the last executed instruction was not a page-set.
    always_ff @(posedge clk) begin
        if (!rst_n)          prev_other <= 1'b0;
        else if (pset_i)     prev_other <= 1'b0;
        else if (|strobes)   prev_other <= 1'b1;
    end

    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == 8'b1000_0000) |=>
        (fetch_addr_o[12:8] == $past(fetch_addr_o[12:8])) &&
        (fetch_addr_o[7:0] == 8'($past(fetch_addr_o[7:0]) + 8'd1)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == 8'd0) |=> $stable(fetch_addr_o));

    p_jump_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> (fetch_addr_o[7:0] == $past(step_op_i)));

    p_pend_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && prev_other) |=> (fetch_addr_o[12:8] == $past(fetch_addr_o[12:8])));

    p_jc_false_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (jcond_i && cond_sel_i == 2'b00 && !carry_i) |=>
        (fetch_addr_o[7:0] == 8'($past(fetch_addr_o[7:0]) + 8'd1)));

    p_push_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_val_o[11:8] == fetch_addr_o[11:8]);

    p_callz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        callz_i |=> (fetch_addr_o[12:8] == 5'd0));

    p_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> (fetch_addr_o[11:0] == $past(ret_val_i)) &&
                  (fetch_addr_o[12] == $past(fetch_addr_o[12])));

    p_retskip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        retskip_i |=> (fetch_addr_o[11:8] == $past(ret_val_i[11:8])) &&
                      (fetch_addr_o[7:0] == 8'($past(ret_val_i[7:0]) + 8'd1)));
endmodule

bind banked_pc_seq pcseq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inc_i        (inc_i),
    .pset_i       (pset_i),
    .jump_i       (jump_i),
    .jcond_i      (jcond_i),
    .call_i       (call_i),
    .callz_i      (callz_i),
    .ret_i        (ret_i),
    .retskip_i    (retskip_i),
    .cond_sel_i   (cond_sel_i),
    .carry_i      (carry_i),
    .step_op_i    (step_op_i),
    .ret_val_i    (ret_val_i),
    .fetch_addr_o (fetch_addr_o),
    .push_val_o   (push_val_o)
);

// File: tb/banked_pc_seq_tb.sv
// Bench for banked_pc_seq: a vector table walked by one loop, then
// directed reset cases. Inputs change at the falling edge; outputs are
// sampled a quarter period after the rising edge.
module banked_pc_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    // op: 0 idle 1 inc 2 pset 3 jump 4 jcond 5 call 6 callz 7 ret 8 retskip
    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  cc;
        logic        c;
        logic        z;
        logic [7:0]  arg;
        logic [4:0]  ps;
        logic [11:0] rv;
        logic [12:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'd1, 2'd0, 1'b0, 1'b0, 8'h00, 5'h00, 12'h000, 13'h0101, 4'd2},  // R2 advance
        '{4'd3, 2'd0, 1'b0, 1'b0, 8'h40, 5'h00, 12'h000, 13'h0140, 4'd3},  // R3 jump in page
        '{4'd2, 2'd0, 1'b0, 1'b0, 8'h00, 5'h1A, 12'h000, 13'h0141, 4'd4},  // R4 page-set advances
        '{4'd3, 2'd0, 1'b0, 1'b0, 8'h22, 5'h00, 12'h000, 13'h1A22, 4'd4},  // R4 jump uses pending
        '{4'd3, 2'd0, 1'b0, 1'b0, 8'h05, 5'h00, 12'h000, 13'h1A05, 4'd5},  // R5 pending expired
        '{4'd2, 2'd0, 1'b0, 1'b0, 8'h00, 5'h03, 12'h000, 13'h1A06, 4'd2},
        '{4'd1, 2'd0, 1'b0, 1'b0, 8'h00, 5'h00, 12'h000, 13'h1A07, 4'd5},  // R5 consumed by advance
        '{4'd3, 2'd0, 1'b0, 1'b0, 8'h10, 5'h00, 12'h000, 13'h1A10, 4'd5},
        '{4'd3, 2'd0, 1'b0, 1'b0, 8'hFF, 5'h00, 12'h000, 13'h1AFF, 4'd3},
        '{4'd1, 2'd0, 1'b0, 1'b0, 8'h00, 5'h00, 12'h000, 13'h1A00, 4'd2},  // R2 step wraps
        '{4'd4, 2'd0, 1'b0, 1'b0, 8'h77, 5'h00, 12'h000, 13'h1A01, 4'd6},  // R6 C=1 false
        '{4'd4, 2'd0, 1'b1, 1'b0, 8'h80, 5'h00, 12'h000, 13'h1A80, 4'd6},  // R6 C=1 true
        '{4'd4, 2'd3, 1'b0, 1'b1, 8'h33, 5'h00, 12'h000, 13'h1A81, 4'd6},  // R6 Z=0 false
        '{4'd4, 2'd2, 1'b0, 1'b1, 8'h33, 5'h00, 12'h000, 13'h1A33, 4'd6},  // R6 Z=1 true
        '{4'd4, 2'd1, 1'b0, 1'b0, 8'h44, 5'h00, 12'h000, 13'h1A44, 4'd6},  // R6 C=0 true
        '{4'd2, 2'd0, 1'b0, 1'b0, 8'h00, 5'h05, 12'h000, 13'h1A45, 4'd4},
        '{4'd5, 2'd0, 1'b0, 1'b0, 8'h12, 5'h00, 12'h000, 13'h0512, 4'd7},  // R7 call with pending
        '{4'd2, 2'd0, 1'b0, 1'b0, 8'h00, 5'h1F, 12'h000, 13'h0513, 4'd8},
        '{4'd6, 2'd0, 1'b0, 1'b0, 8'h30, 5'h00, 12'h000, 13'h0030, 4'd8},  // R8 zero-page call
        '{4'd3, 2'd0, 1'b0, 1'b0, 8'h01, 5'h00, 12'h000, 13'h0001, 4'd8},  // R8 pending cancelled
        '{4'd7, 2'd0, 1'b0, 1'b0, 8'h00, 5'h00, 12'hA45, 13'h0A45, 4'd9},  // R9 return
        '{4'd8, 2'd0, 1'b0, 1'b0, 8'h00, 5'h00, 12'h345, 13'h0346, 4'd10}, // R10 return-skip
        '{4'd8, 2'd0, 1'b0, 1'b0, 8'h00, 5'h00, 12'h2FF, 13'h0200, 4'd10}, // R10 skip wraps
        '{4'd0, 2'd0, 1'b0, 1'b0, 8'h00, 5'h00, 12'h000, 13'h0200, 4'd2},  // R2 idle holds
        '{4'd4, 2'd3, 1'b0, 1'b0, 8'h9C, 5'h00, 12'h000, 13'h029C, 4'd6},  // R6 Z=0 true
        '{4'd4, 2'd1, 1'b1, 1'b0, 8'h11, 5'h00, 12'h000, 13'h029D, 4'd6},  // R6 C=0 false
        '{4'd5, 2'd0, 1'b0, 1'b0, 8'h7E, 5'h00, 12'h000, 13'h027E, 4'd7}   // R7 call in page
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_i = 0, pset_i = 0, jump_i = 0, jcond_i = 0;
    logic        call_i = 0, callz_i = 0, ret_i = 0, retskip_i = 0;
    logic [1:0]  cond_sel_i = 0;
    logic        carry_i = 0, zero_i = 0;
    logic [7:0]  step_op_i = 0;
    logic [4:0]  page_op_i = 0;
    logic [11:0] ret_val_i = 0;
    logic [12:0] fetch_addr_o;
    logic [11:0] push_val_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_pc_seq u_dut (
        .clk (clk), .rst_n (rst_n),
        .inc_i (inc_i), .pset_i (pset_i), .jump_i (jump_i), .jcond_i (jcond_i),
        .call_i (call_i), .callz_i (callz_i), .ret_i (ret_i), .retskip_i (retskip_i),
        .cond_sel_i (cond_sel_i), .carry_i (carry_i), .zero_i (zero_i),
        .step_op_i (step_op_i), .page_op_i (page_op_i), .ret_val_i (ret_val_i),
        .fetch_addr_o (fetch_addr_o), .push_val_o (push_val_o)
    );

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one instruction at the falling edge, sample after the rising edge.
    task automatic apply(input vec_t v);
        @(negedge clk);
        inc_i = (v.op == 4'd1); pset_i = (v.op == 4'd2); jump_i = (v.op == 4'd3);
        jcond_i = (v.op == 4'd4); call_i = (v.op == 4'd5); callz_i = (v.op == 4'd6);
        ret_i = (v.op == 4'd7); retskip_i = (v.op == 4'd8);
        cond_sel_i = v.cc; carry_i = v.c; zero_i = v.z;
        step_op_i = v.arg; page_op_i = v.ps; ret_val_i = v.rv;
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    function automatic vec_t mk(input logic [3:0] op, input logic [7:0] arg, input logic [4:0] ps);
        vec_t v;
        v = '0; v.op = op; v.arg = arg; v.ps = ps;
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD / 4);
        check("R1 reset addr", fetch_addr_o, 13'h0100);
        check("R7 push after reset", {1'b0, push_val_o}, 13'h0101);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("R%0d vector %0d addr", VECS[i].req, i), fetch_addr_o, VECS[i].exp);
            // R7: push value is {page, step+1} of the current address
            check($sformatf("R7 vector %0d push", i), {1'b0, push_val_o},
                  {1'b0, VECS[i].exp[11:8], 8'(VECS[i].exp[7:0] + 8'd1)});
        end

        // R1: reset in the middle discards a live page-set
        apply(mk(4'd2, 8'h00, 5'h1F));
        @(negedge clk);
        rst_n = 1'b0;
        apply(mk(4'd0, 8'h00, 5'h00));
        @(negedge clk);
        rst_n = 1'b1;
        apply(mk(4'd3, 8'h10, 5'h00));
        check("R1 pending cleared by reset", fetch_addr_o, 13'h0110);

        // R4: bank-only page-set followed by a call
        apply(mk(4'd2, 8'h00, 5'h10));
        apply(mk(4'd5, 8'hC3, 5'h00));
        check("R4 bank bit via call", fetch_addr_o, 13'h10C3);

        @(negedge clk);
        {inc_i, pset_i, jump_i, jcond_i, call_i, callz_i, ret_i, retskip_i} = '0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule